// File: doc/BRIEF.md
# Indexed Odd-Lane Operand Selector

This block is the operand routing stage for a widening, indexed multiply-subtract on one vector register of `VL` bits, with `VL` a multiple of 128. The result is built from 32-bit lanes. For each lane it sends three operands to the lane arithmetic:
- the upper (odd-numbered) 16-bit half of the matching 32-bit slot of the first source;
- one 16-bit element of the second source, chosen by a 3-bit index and shared by all four lanes of the same 128-bit segment;
- the 32-bit addend lane, passed through unchanged.

The block is purely combinational. From the same 32-bit instruction word it also extracts the destination/addend register number, both source register numbers and the index. It raises a flag when the word carries the fixed opcode bits of the top-half subtract form. The operation is unpredicated, so every lane's operands are always produced. Negation, the multiply-add itself and register storage sit in other blocks.

Top module: `ioos_sel`

## Requirements
- R1: There are VL/32 output lanes. Addend lane e (`op3_o[32e+31:32e]`) equals `acc_i[32e+31:32e]` for every lane.
- R2: First-multiplicand lane e (`op1_o[16e+15:16e]`) equals 16-bit element 2e+1 of `src1_i`, i.e. `src1_i[32e+31:32e+16]`.
- R3: Second-multiplicand lane e (`op2_o[16e+15:16e]`) equals 16-bit element 8*floor(e/4)+idx of `src2_i`, so all four lanes of a 128-bit segment carry the same element, taken from that segment.
- R4: The index is `idx_o = {insn_i[20:19], insn_i[11]}` and takes every value 0 to 7.
- R5: `rd_o = insn_i[4:0]`, `rn_o = insn_i[9:5]`, and `rm_o = insn_i[18:16]` is 3 bits wide, so it names registers 0 to 7 only.
- R6: `valid_o` is 1 exactly when `insn_i[31:21] = 11'b01100100101`, `insn_i[15:12] = 4'b0110` and `insn_i[10] = 1`. A wrong value in any one of these bits drives it to 0.
- R7: The even-numbered 16-bit elements of `src1_i` (bits `32e+15:32e`) have no effect on any output.
- R8: Operand outputs follow R1 to R3 whatever `valid_o` is: lanes are never masked or zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| src1_i | input | VL | First source vector (16-bit elements) |
| src2_i | input | VL | Second source vector (16-bit elements) |
| acc_i | input | VL | Addend vector (32-bit lanes) |
| op1_o | output | VL/2 | Per-lane odd half of first source |
| op2_o | output | VL/2 | Per-lane segment-broadcast element of second source |
| op3_o | output | VL | Per-lane addend word |
| rd_o | output | 5 | Destination/addend register number |
| rn_o | output | 5 | First source register number |
| rm_o | output | 3 | Second source register number |
| idx_o | output | 3 | Element index within a segment |
| valid_o | output | 1 | Fixed opcode bits match |

## Verification
Vectors whose 16-bit elements each hold their own position number show exactly which element lands in each lane. They catch an off-by-one on the odd half, or a segment base that is wrong, for all eight index values. Random vectors paired with flips of each index bit separate the high pair from the low bit. Changing only the even halves of the first source shows that those halves are ignored. Words with one fixed opcode bit wrong at a time clear the valid flag and leave the routed operands unchanged.

// File: rtl/ioos_pkg.sv
package ioos_pkg;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned SEG_W  = 128;
  localparam int unsigned LANES_PER_SEG = SEG_W / LANE_W;
  localparam int unsigned HALVES_PER_SEG = SEG_W / HALF_W;
  localparam int unsigned IDX_W = $clog2(HALVES_PER_SEG);

  localparam logic [10:0] OPC_HI  = 11'b01100100101;
  localparam logic [3:0]  OPC_MID = 4'b0110;

  typedef struct packed {
    logic [4:0]       rd;
    logic [4:0]       rn;
    logic [2:0]       rm;
    logic [IDX_W-1:0] idx;
    logic             valid;
  } dec_t;
endpackage

// File: rtl/ioos_decode.sv
module ioos_decode
  import ioos_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  logic hi_ok, mid_ok, top_ok;

  assign hi_ok  = (insn_i[31:21] == OPC_HI);
  assign mid_ok = (insn_i[15:12] == OPC_MID);
  assign top_ok = insn_i[10];

  always_comb begin
    dec_o.rd    = insn_i[4:0];
    dec_o.rn    = insn_i[9:5];
    dec_o.rm    = insn_i[18:16];
    // split index: upper pair high, single bit low
    dec_o.idx   = {insn_i[20:19], insn_i[11]};
    dec_o.valid = hi_ok & mid_ok & top_ok;
  end
endmodule

// File: rtl/ioos_odd_pick.sv
module ioos_odd_pick
  import ioos_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic [VL-1:0]   src_i,
  output logic [VL/2-1:0] odd_o
);
  localparam int unsigned N_LANE = VL / LANE_W;

  for (genvar e = 0; e < N_LANE; e++) begin : g_lane
    assign odd_o[e*HALF_W +: HALF_W] = src_i[e*LANE_W + HALF_W +: HALF_W];
  end
endmodule

// File: rtl/ioos_seg_bcast.sv
module ioos_seg_bcast
  import ioos_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic [VL-1:0]    src_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [VL/2-1:0]  bcast_o
);
  localparam int unsigned N_SEG = VL / SEG_W;

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    logic [SEG_W-1:0]  seg;
    logic [HALF_W-1:0] pick;

    assign seg = src_i[s*SEG_W +: SEG_W];

    always_comb begin
      pick = '0;
      for (int h = 0; h < HALVES_PER_SEG; h++) begin
        if (idx_i == IDX_W'(h)) pick = seg[h*HALF_W +: HALF_W];
      end
    end

    for (genvar l = 0; l < LANES_PER_SEG; l++) begin : g_rep
      assign bcast_o[(s*LANES_PER_SEG + l)*HALF_W +: HALF_W] = pick;
    end
  end
endmodule

// File: rtl/ioos_sel.sv
module ioos_sel
  import ioos_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic [31:0]     insn_i,
  input  logic [VL-1:0]   src1_i,
  input  logic [VL-1:0]   src2_i,
  input  logic [VL-1:0]   acc_i,
  output logic [VL/2-1:0] op1_o,
  output logic [VL/2-1:0] op2_o,
  output logic [VL-1:0]   op3_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rn_o,
  output logic [2:0]      rm_o,
  output logic [2:0]      idx_o,
  output logic            valid_o
);
  dec_t dec;

  ioos_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  ioos_odd_pick #(.VL(VL)) u_odd (
    .src_i (src1_i),
    .odd_o (op1_o)
  );

  ioos_seg_bcast #(.VL(VL)) u_bc (
    .src_i   (src2_i),
    .idx_i   (dec.idx),
    .bcast_o (op2_o)
  );

  assign op3_o   = acc_i;  // unpredicated: every lane written
  assign rd_o    = dec.rd;
  assign rn_o    = dec.rn;
  assign rm_o    = dec.rm;
  assign idx_o   = dec.idx;
  assign valid_o = dec.valid;
endmodule

// File: rtl/ioos_sel_chk.sv
module ioos_sel_chk #(
  parameter int unsigned VL = 256
) (
  input logic [31:0]     insn_i,
  input logic [VL-1:0]   src1_i,
  input logic [VL-1:0]   src2_i,
  input logic [VL-1:0]   acc_i,
  input logic [VL/2-1:0] op1_o,
  input logic [VL/2-1:0] op2_o,
  input logic [VL-1:0]   op3_o,
  input logic [2:0]      idx_o,
  input logic            valid_o
);
  localparam int unsigned N_LANE = VL / 32;

  always_comb begin
    for (int e = 0; e < N_LANE; e++) begin
      p_addend_lane_r1: assert (op3_o[e*32 +: 32] == acc_i[e*32 +: 32]);
      p_odd_half_r2: assert (op1_o[e*16 +: 16] == src1_i[e*32 + 16 +: 16]);
      p_seg_elem_r3: assert (op2_o[e*16 +: 16] == src2_i[((e/4)*8 + int'(idx_o))*16 +: 16]);
      if (e % 4 != 0) begin
        p_seg_same_r3: assert (op2_o[e*16 +: 16] == op2_o[(e-1)*16 +: 16]);
      end
    end
    p_idx_bits_r4: assert (idx_o == {insn_i[20:19], insn_i[11]});
    p_valid_top_r6: assert (!valid_o || (insn_i[10] && insn_i[14:13] == 2'b11));
  end
endmodule

bind ioos_sel ioos_sel_chk #(.VL(VL)) u_chk (
  .insn_i  (insn_i),
  .src1_i  (src1_i),
  .src2_i  (src2_i),
  .acc_i   (acc_i),
  .op1_o   (op1_o),
  .op2_o   (op2_o),
  .op3_o   (op3_o),
  .idx_o   (idx_o),
  .valid_o (valid_o)
);

// File: tb/ioos_sel_tb.sv
`timescale 1ns/1ps
module ioos_sel_tb;
  localparam int unsigned VL = 256;
  localparam int unsigned NL = VL / 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [31:0]     insn;
  logic [VL-1:0]   s1, s2, acc;
  logic [VL/2-1:0] op1, op2;
  logic [VL-1:0]   op3;
  logic [4:0]      rd, rn;
  logic [2:0]      rm, idx;
  logic            vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ioos_sel #(.VL(VL)) u_dut (
    .insn_i (insn), .src1_i (s1), .src2_i (s2), .acc_i (acc),
    .op1_o (op1), .op2_o (op2), .op3_o (op3),
    .rd_o (rd), .rn_o (rn), .rm_o (rm), .idx_o (idx), .valid_o (vld)
  );

  function automatic logic [31:0] mk(input logic [4:0] d, input logic [4:0] n,
                                     input logic [2:0] m, input logic [2:0] x);
    return {11'b01100100101, x[2:1], m, 4'b0110, x[0], 1'b1, n, d};
  endfunction

  function automatic logic [VL-1:0] rnd();
    logic [VL-1:0] v;
    for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VL-1:0] ramp(input logic [7:0] tag);
    logic [VL-1:0] v;
    for (int i = 0; i < VL/16; i++) v[i*16 +: 16] = {tag, 8'(i)};
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // reference model evaluated from current inputs, compared at negedge
  task automatic compare();
    logic [VL/2-1:0] e1, e2;
    logic [2:0] ex;
    bit ev;
    ex = {insn[20:19], insn[11]};
    ev = (insn[31:21] == 11'h325) && (insn[15:12] == 4'h6) && insn[10];
    for (int e = 0; e < NL; e++) begin
      int s;
      e1[e*16 +: 16] = s1[(2*e+1)*16 +: 16];
      s = (e - (e % 4)) * 2 + int'(ex);
      e2[e*16 +: 16] = s2[s*16 +: 16];
    end
    @(negedge clk);
    chk(op3 == acc, "R1", "op3", op3, acc);
    chk(op1 == e1, "R2", "op1", op1, e1);
    chk(op2 == e2, "R3", "op2", op2, e2);
    chk(idx == ex, "R4", "idx", idx, ex);
    chk({rd, rn, rm} == {insn[4:0], insn[9:5], insn[18:16]}, "R5", "regs",
        {rd, rn, rm}, {insn[4:0], insn[9:5], insn[18:16]});
    chk(vld == ev, "R6", "valid", vld, ev);
  endtask

  task automatic apply(input logic [31:0] w, input logic [VL-1:0] a,
                       input logic [VL-1:0] b, input logic [VL-1:0] c);
    @(posedge clk);
    #1;
    insn = w; s1 = a; s2 = b; acc = c;
    compare();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    insn = '0; s1 = '0; s2 = '0; acc = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(op1 == '0 && op2 == '0 && op3 == '0, "R1", "idle", {op1, op2}, '0);
    rst_ni = 1'b1;

    // ramp vectors, every index value (R3, R4)
    for (int x = 0; x < 8; x++)
      apply(mk(5'(x + 3), 5'(31 - x), 3'(x), 3'(x)), ramp(8'hA1), ramp(8'hB2), rnd());

    // register fields at extremes (R5)
    apply(mk(5'h1f, 5'h00, 3'h7, 3'h0), rnd(), rnd(), rnd());
    apply(mk(5'h00, 5'h1f, 3'h0, 3'h7), rnd(), rnd(), rnd());

    // single index bit flips on random data (R4)
    for (int b = 0; b < 3; b++)
      apply(mk(5'h4, 5'h9, 3'h2, 3'(1 << b)), rnd(), rnd(), rnd());

    // R7: only even halves of src1 change, op1 must not move
    begin
      logic [VL-1:0] a, a2, b, c;
      logic [VL/2-1:0] keep;
      a = rnd(); b = rnd(); c = rnd();
      apply(mk(5'h1, 5'h2, 3'h3, 3'h5), a, b, c);
      keep = op1;
      a2 = a;
      for (int e = 0; e < NL; e++) a2[e*32 +: 16] = ~a[e*32 +: 16];
      apply(mk(5'h1, 5'h2, 3'h3, 3'h5), a2, b, c);
      chk(op1 == keep, "R7", "even halves ignored", op1, keep);
    end

    // R6 and R8: flip each fixed bit, valid drops, operands still routed
    begin
      int fixed_bits[16] = '{31,30,29,28,27,26,25,24,23,22,21,15,14,13,12,10};
      for (int k = 0; k < 16; k++) begin
        logic [31:0] w;
        w = mk(5'h6, 5'h7, 3'h1, 3'h6);
        w[fixed_bits[k]] = ~w[fixed_bits[k]];
        apply(w, ramp(8'hC3), rnd(), rnd());
        chk(op3 != '0 || acc == '0, "R8", "lanes not masked", op3, acc);
      end
    end

    // random sweep
    for (int i = 0; i < 40; i++)
      apply(mk(5'($urandom), 5'($urandom), 3'($urandom), 3'($urandom)), rnd(), rnd(), rnd());

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule